// File: doc/BRIEF.md
# Windowed External Interrupt Register Array

This block keeps the per-line control and status state for a configurable number of level-sensitive external interrupt lines, up to 512. Software reaches it through a 32-bit CSR-style port. Each access names one of four arrays (enable, pending, force, priority) and an operation (read, write, set bits, clear bits). Every array is wider than the port, so each access sees a 16-bit slice of the array, carried in bits 31:16 of the CSR value. The slice is picked by the low bits of the write data of that same access.

A line counts as pending while its input is high or its force bit is set. The block raises a single external interrupt request toward the core when at least one line is pending, enabled, and has a priority at or above the current preemption level. The pending array and the request are combinational in the inputs. The control arrays change on the clock edge that ends a writing access.

Top module: `irq_window_bank`

## Requirements
- R1: After a synchronous active-low reset, every enable bit, force bit and priority field is 0. Reading any window of those arrays then returns 32'h0.
- R2: Window data is in csr_rdata[31:16] and csr_rdata[15:0] is always 0. For enable, pending and force, the window index is csr_wdata[4:0], and bit b of window w is line 16*w+b. Operation 0 (read) performs no write and always uses window 0.
- R3: csr_op encodes 0 read, 1 write, 2 set bits, 3 clear bits. csr_sel encodes 0 enable, 1 pending, 2 force, 3 priority. Write replaces the window with csr_wdata[31:16]. Set and clear affect only the window bits whose data bit is 1. The index field is never stored. csr_rdata shows the window value from before the access, and the update takes effect at the next clock edge.
- R4: Pending bit i reads as irq_in[i] OR force bit i. Writes, sets and clears with csr_sel 1 change no state.
- R5: Setting a force bit makes that line pending even with its input low. Clearing it removes the pending state unless the input is high.
- R6: For csr_sel 3, the window index is csr_wdata[6:0]. Field f, in bits 16+4f+3:16+4f, is the 4-bit priority of line 4*w+f. Write, set and clear apply per field bit.
- R7: Only the PRIO_BITS most significant bits of each priority field are stored. The remaining low bits always read 0.
- R8: ext_irq_pending is 1 exactly when some line is pending, enabled, and has a priority greater than or equal to preempt_lvl. A line below the level still shows in the pending array.
- R9: Bits for lines at or above NUM_IRQ read 0 and ignore writes. Whole windows beyond NUM_IRQ read 0.
- R10: An access with operation 0 leaves every array unchanged, whatever csr_wdata holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_IRQ | Level-sensitive interrupt request lines |
| csr_op | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| csr_sel | input | 2 | Array: 0 enable, 1 pending, 2 force, 3 priority |
| csr_wdata | input | 32 | Window data in 31:16, window index in the low bits |
| csr_rdata | output | 32 | Selected window in 31:16, zero below |
| preempt_lvl | input | 4 | Current preemption priority |
| ext_irq_pending | output | 1 | External interrupt request to the core |

## Verification
The bench builds the block with NUM_IRQ = 40 and PRIO_BITS = 2. A line count that is not a multiple of 16 leaves window 2 half implemented and makes window 3 and priority window 10 wholly absent, so the out-of-range rules can be checked. With two stored priority bits, the hardwired low field bits show up on every priority readback. The bench also places the preemption level against a stored priority to hit the equal and just-below cases of the threshold.

// File: rtl/irqwin_pkg.sv
// Shared encodings and fixed geometry of the windowed interrupt register
// array. Assumes a maximum of 512 lines and a 16-bit window data field.
package irqwin_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        ARR_ENABLE   = 2'd0,
        ARR_PENDING  = 2'd1,
        ARR_FORCE    = 2'd2,
        ARR_PRIORITY = 2'd3
    } arr_sel_e;

    localparam int MAX_IRQ    = 512;
    localparam int WIN_W      = 16;
    localparam int FIELD_W    = 4;
    localparam int FIELDS_WIN = WIN_W / FIELD_W;
    localparam int BIT_IDX_W  = $clog2(MAX_IRQ / WIN_W);
    localparam int PRI_IDX_W  = $clog2(MAX_IRQ / FIELDS_WIN);
endpackage

// File: rtl/irqwin_win_read.sv
// Extracts one 16-bit window from a per-line bit vector.
// Assumes lines at or above NUM_IRQ do not exist and read as zero.
module irqwin_win_read
    import irqwin_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]   vec,
    input  logic [BIT_IDX_W-1:0] win,
    output logic [WIN_W-1:0]     data
);
    localparam int NWIN = (NUM_IRQ + WIN_W - 1) / WIN_W;

    for (genvar b = 0; b < WIN_W; b++) begin : g_bit
        logic [NWIN-1:0] col;
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            if (w * WIN_W + b < NUM_IRQ) begin : g_real
                assign col[w] = vec[w * WIN_W + b] & (win == BIT_IDX_W'(w));
            end else begin : g_absent
                assign col[w] = 1'b0;
            end
        end
        assign data[b] = |col;
    end
endmodule

// File: rtl/irqwin_bitarray.sv
// One per-line control bit array (enable or force) updated through a
// 16-bit window with write / set / clear semantics.
// Assumes the caller asserts we only for writing operations on this array.
module irqwin_bitarray
    import irqwin_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [1:0]           op,
    input  logic [BIT_IDX_W-1:0] win,
    input  logic [WIN_W-1:0]     wdat,
    output logic [NUM_IRQ-1:0]   bits_q
);
    logic [NUM_IRQ-1:0] hit;
    logic [NUM_IRQ-1:0] dbit;
    logic [NUM_IRQ-1:0] touch;
    logic [NUM_IRQ-1:0] bits_d;

    // Map each line to its window and its data bit within the window
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        assign hit[i]  = (win == BIT_IDX_W'(i / WIN_W));
        assign dbit[i] = wdat[i % WIN_W];
    end

    assign touch = hit & dbit;

    // Next array value for the requested operation
    always_comb begin
        unique case (csr_op_e'(op))
            OP_WRITE: bits_d = (bits_q & ~hit) | touch;
            OP_SET:   bits_d = bits_q | touch;
            OP_CLEAR: bits_d = bits_q & ~touch;
            default:  bits_d = bits_q;
        endcase
    end

    // Array register with synchronous reset to all-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (we) begin
            bits_q <= bits_d;
        end
    end

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_SET) |=> ((bits_q & $past(touch)) == $past(touch)));
    // R3
    clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_CLEAR) |=> ((bits_q & $past(touch)) == '0));
    // R3
    outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((bits_q & ~$past(hit)) == ($past(bits_q) & ~$past(hit))));
    // R10
    hold_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(bits_q));
endmodule

// File: rtl/irqwin_prio_array.sv
// Per-line priority storage reached through 16-bit windows of four 4-bit
// fields. Only the PRIO_BITS upper bits of each field are stored.
// Assumes PRIO_BITS is between 1 and 4.
module irqwin_prio_array
    import irqwin_pkg::*;
#(
    parameter int NUM_IRQ   = 64,
    parameter int PRIO_BITS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [1:0]                   op,
    input  logic [PRI_IDX_W-1:0]         win,
    input  logic [WIN_W-1:0]             wdat,
    output logic [NUM_IRQ*FIELD_W-1:0]   lvl_full,
    output logic [WIN_W-1:0]             rd
);
    localparam int LOW_W = FIELD_W - PRIO_BITS;
    localparam int NPW   = (NUM_IRQ + FIELDS_WIN - 1) / FIELDS_WIN;

    logic [NUM_IRQ*PRIO_BITS-1:0] lvl_q;
    logic [NUM_IRQ*PRIO_BITS-1:0] lvl_d;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        localparam int F = i % FIELDS_WIN;
        logic               hit;
        logic [FIELD_W-1:0] old4;
        logic [FIELD_W-1:0] d4;
        logic [FIELD_W-1:0] new4;

        assign hit  = (win == PRI_IDX_W'(i / FIELDS_WIN));
        assign old4 = FIELD_W'(lvl_q[i*PRIO_BITS +: PRIO_BITS]) << LOW_W;
        assign d4   = wdat[F*FIELD_W +: FIELD_W];
        assign lvl_full[i*FIELD_W +: FIELD_W] = old4;

        // Field value after the requested operation
        always_comb begin
            unique case (csr_op_e'(op))
                OP_WRITE: new4 = d4;
                OP_SET:   new4 = old4 | d4;
                OP_CLEAR: new4 = old4 & ~d4;
                default:  new4 = old4;
            endcase
        end

        assign lvl_d[i*PRIO_BITS +: PRIO_BITS] =
            hit ? new4[FIELD_W-1 -: PRIO_BITS] : lvl_q[i*PRIO_BITS +: PRIO_BITS];
    end

    // Priority register with synchronous reset to level 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (we) begin
            lvl_q <= lvl_d;
        end
    end

    for (genvar f = 0; f < FIELDS_WIN; f++) begin : g_field
        // Gather field f of the selected window
        always_comb begin
            rd[f*FIELD_W +: FIELD_W] = '0;
            for (int w = 0; w < NPW; w++) begin
                if ((w * FIELDS_WIN + f < NUM_IRQ) && (win == PRI_IDX_W'(w))) begin
                    rd[f*FIELD_W +: FIELD_W] = lvl_full[(w*FIELDS_WIN + f)*FIELD_W +: FIELD_W];
                end
            end
        end
    end

    // R10
    hold_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(lvl_q));
    // R6
    write_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_WRITE && win == '0) |=>
            (lvl_full[FIELD_W-1:0] == ($past(wdat[FIELD_W-1:0]) & (4'hF << LOW_W))));
endmodule

// File: rtl/irqwin_notify.sv
// Reduces per-line pending, enable and priority state to the single
// external interrupt request. Purely combinational.
module irqwin_notify
    import irqwin_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]         pend,
    input  logic [NUM_IRQ-1:0]         en,
    input  logic [NUM_IRQ*FIELD_W-1:0] lvl_full,
    input  logic [FIELD_W-1:0]         preempt,
    output logic                       req
);
    logic [NUM_IRQ-1:0] elig;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        assign elig[i] = pend[i] & en[i] & (lvl_full[i*FIELD_W +: FIELD_W] >= preempt);
    end

    assign req = |elig;
endmodule

// File: rtl/irq_window_bank.sv
// Top of the windowed external interrupt register array. Decodes the CSR
// access, routes it to the enable, force and priority stores, forms the
// pending array and drives the external interrupt request.
// Assumes NUM_IRQ <= 512 and a single access per cycle; read data is
// combinational and reflects state before the access's clock edge.
module irq_window_bank
    import irqwin_pkg::*;
#(
    parameter int NUM_IRQ   = 64,
    parameter int PRIO_BITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [1:0]         csr_op,
    input  logic [1:0]         csr_sel,
    input  logic [31:0]        csr_wdata,
    output logic [31:0]        csr_rdata,
    input  logic [3:0]         preempt_lvl,
    output logic               ext_irq_pending
);
    logic                       is_write;
    logic [BIT_IDX_W-1:0]       bit_win;
    logic [PRI_IDX_W-1:0]       pri_win;
    logic [WIN_W-1:0]           wdat;
    logic [NUM_IRQ-1:0]         en_q;
    logic [NUM_IRQ-1:0]         frc_q;
    logic [NUM_IRQ-1:0]         pend_vec;
    logic [NUM_IRQ*FIELD_W-1:0] lvl_full;
    logic [WIN_W-1:0]           en_rd;
    logic [WIN_W-1:0]           pend_rd;
    logic [WIN_W-1:0]           frc_rd;
    logic [WIN_W-1:0]           pri_rd;
    logic [WIN_W-1:0]           win_rd;
    logic                       unused_wdata;

    // Window selection: a read-only access addresses window 0
    assign is_write     = (csr_op != OP_READ);
    assign bit_win      = is_write ? csr_wdata[BIT_IDX_W-1:0] : '0;
    assign pri_win      = is_write ? csr_wdata[PRI_IDX_W-1:0] : '0;
    assign wdat         = csr_wdata[31:16];
    assign unused_wdata = ^csr_wdata[15:PRI_IDX_W];

    irqwin_bitarray #(.NUM_IRQ(NUM_IRQ)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (is_write && csr_sel == ARR_ENABLE),
        .op    (csr_op),
        .win   (bit_win),
        .wdat  (wdat),
        .bits_q(en_q)
    );

    irqwin_bitarray #(.NUM_IRQ(NUM_IRQ)) u_force (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (is_write && csr_sel == ARR_FORCE),
        .op    (csr_op),
        .win   (bit_win),
        .wdat  (wdat),
        .bits_q(frc_q)
    );

    irqwin_prio_array #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (is_write && csr_sel == ARR_PRIORITY),
        .op      (csr_op),
        .win     (pri_win),
        .wdat    (wdat),
        .lvl_full(lvl_full),
        .rd      (pri_rd)
    );

    assign pend_vec = irq_in | frc_q;

    irqwin_win_read #(.NUM_IRQ(NUM_IRQ)) u_rd_en (
        .vec(en_q), .win(bit_win), .data(en_rd)
    );
    irqwin_win_read #(.NUM_IRQ(NUM_IRQ)) u_rd_pend (
        .vec(pend_vec), .win(bit_win), .data(pend_rd)
    );
    irqwin_win_read #(.NUM_IRQ(NUM_IRQ)) u_rd_frc (
        .vec(frc_q), .win(bit_win), .data(frc_rd)
    );

    // Read-data multiplexer over the four arrays
    always_comb begin
        unique case (arr_sel_e'(csr_sel))
            ARR_ENABLE:  win_rd = en_rd;
            ARR_PENDING: win_rd = pend_rd;
            ARR_FORCE:   win_rd = frc_rd;
            default:     win_rd = pri_rd;
        endcase
    end
    assign csr_rdata = {win_rd, 16'h0000};

    irqwin_notify #(.NUM_IRQ(NUM_IRQ)) u_notify (
        .pend    (pend_vec),
        .en      (en_q),
        .lvl_full(lvl_full),
        .preempt (preempt_lvl),
        .req     (ext_irq_pending)
    );

    // R8
    req_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq_pending |-> (|(pend_vec & en_q)));
    // R8
    req_at_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((preempt_lvl == 4'd0) && (|(pend_vec & en_q))) |-> ext_irq_pending);
    // R4
    pending_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_sel == ARR_PENDING) |=> ($stable(frc_q) && $stable(en_q)));
endmodule

// File: tb/irq_window_bank_tb.sv
// Self-checking bench: a behavioural model of the arrays predicts every
// read and the interrupt request on every clock.
module irq_window_bank_tb;
    localparam int N  = 40;
    localparam int PB = 2;
    localparam logic [3:0] PMASK = 4'hF << (4 - PB);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_v = '0;
    logic [1:0]  op_r = 2'd0;
    logic [1:0]  sel_r = 2'd0;
    logic [31:0] wd_r = 32'h0;
    logic [3:0]  pre_r = 4'd0;
    logic [31:0] csr_rdata;
    logic        ext_irq_pending;

    int checks = 0;
    int failures = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    bit        en_m [N];
    bit        fr_m [N];
    logic [3:0] pr_m [N];

    always #4 clk = ~clk;

    irq_window_bank #(.NUM_IRQ(N), .PRIO_BITS(PB)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .irq_in         (irq_v),
        .csr_op         (op_r),
        .csr_sel        (sel_r),
        .csr_wdata      (wd_r),
        .csr_rdata      (csr_rdata),
        .preempt_lvl    (pre_r),
        .ext_irq_pending(ext_irq_pending)
    );

    function automatic logic [31:0] exp_rd(logic [1:0] op, logic [1:0] sel, logic [31:0] wd);
        int wb = (op == 2'd0) ? 0 : int'(wd[4:0]);
        int wp = (op == 2'd0) ? 0 : int'(wd[6:0]);
        logic [15:0] r = '0;
        if (sel == 2'd3) begin
            for (int f = 0; f < 4; f++) begin
                int idx = wp * 4 + f;
                if (idx < N) r[f*4 +: 4] = pr_m[idx];
            end
        end else begin
            for (int b = 0; b < 16; b++) begin
                int idx = wb * 16 + b;
                if (idx < N) begin
                    if (sel == 2'd0) r[b] = en_m[idx];
                    else if (sel == 2'd1) r[b] = irq_v[idx] | fr_m[idx];
                    else r[b] = fr_m[idx];
                end
            end
        end
        return {r, 16'h0000};
    endfunction

    function automatic bit opb(logic [1:0] op, bit old, bit d);
        case (op)
            2'd1: return d;
            2'd2: return old | d;
            2'd3: return old & ~d;
            default: return old;
        endcase
    endfunction

    task automatic model_update(logic [1:0] op, logic [1:0] sel, logic [31:0] wd);
        if (op == 2'd0 || sel == 2'd1) return;
        if (sel == 2'd3) begin
            for (int f = 0; f < 4; f++) begin
                int idx = int'(wd[6:0]) * 4 + f;
                if (idx < N) begin
                    logic [3:0] nv;
                    for (int k = 0; k < 4; k++) nv[k] = opb(op, pr_m[idx][k], wd[16 + f*4 + k]);
                    pr_m[idx] = nv & PMASK;
                end
            end
        end else begin
            for (int b = 0; b < 16; b++) begin
                int idx = int'(wd[4:0]) * 16 + b;
                if (idx < N) begin
                    if (sel == 2'd0) en_m[idx] = opb(op, en_m[idx], wd[16 + b]);
                    else fr_m[idx] = opb(op, fr_m[idx], wd[16 + b]);
                end
            end
        end
    endtask

    function automatic bit exp_ext();
        for (int i = 0; i < N; i++) begin
            if ((irq_v[i] | fr_m[i]) && en_m[i] && (pr_m[i] >= pre_r)) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: drive, check read data, let the edge update, then idle
    task automatic acc(logic [1:0] op, logic [1:0] sel, logic [31:0] wd, string tag);
        @(negedge clk);
        op_r = op; sel_r = sel; wd_r = wd;
        #1;
        chk(csr_rdata, exp_rd(op, sel, wd), tag);
        @(posedge clk);
        #1;
        model_update(op, sel, wd);
        @(negedge clk);
        op_r = 2'd0; wd_r = 32'h0;
    endtask

    task automatic set_line(int idx, bit v);
        @(negedge clk);
        irq_v[idx] = v;
    endtask

    task automatic set_pre(logic [3:0] p, bit exp, string tag);
        @(negedge clk);
        pre_r = p;
        #2;
        chk({31'h0, ext_irq_pending}, {31'h0, exp}, tag);
    endtask

    // Per-clock comparison of the interrupt request against the model (R8)
    always @(negedge clk) begin
        if (chk_on) begin
            #2;
            chk({31'h0, ext_irq_pending}, {31'h0, exp_ext()}, "R8 per-clock request");
        end
    end

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin en_m[i] = 0; fr_m[i] = 0; pr_m[i] = 4'h0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R1 reset state
        acc(2'd0, 2'd0, 32'h0, "R1 enable window 0 after reset");
        acc(2'd2, 2'd2, 32'h0000_0001, "R1 force window 1 after reset");
        acc(2'd2, 2'd3, 32'h0000_0005, "R1 priority window 5 after reset");

        // R3 write / set / clear on enable
        acc(2'd1, 2'd0, 32'hA5A5_0000, "R3 write enable window 0");
        acc(2'd2, 2'd0, 32'h0000_0000, "R3 readback enable window 0");
        acc(2'd2, 2'd0, 32'h0F00_0001, "R3 set enable window 1");
        acc(2'd3, 2'd0, 32'h0300_0001, "R3 clear enable window 1");
        acc(2'd2, 2'd0, 32'h0000_0001, "R3 readback enable window 1");
        acc(2'd3, 2'd0, 32'h0000_001F, "R3 index bits not stored");

        // R2 read op always uses window 0 and leaves state (R10)
        acc(2'd0, 2'd0, 32'hFFFF_0001, "R2 read uses window 0");
        acc(2'd0, 2'd2, 32'hFFFF_0002, "R10 read op with data");
        acc(2'd2, 2'd2, 32'h0000_0002, "R10 force window 2 unchanged");

        // R4 pending follows inputs and is read-only
        set_line(3, 1'b1);
        set_line(17, 1'b1);
        acc(2'd2, 2'd1, 32'h0000_0000, "R4 pending window 0");
        acc(2'd1, 2'd1, 32'h0000_0001, "R4 write to pending window 1");
        acc(2'd2, 2'd1, 32'h0000_0001, "R4 pending window 1 unchanged");
        set_line(3, 1'b0);
        acc(2'd2, 2'd1, 32'h0000_0000, "R4 pending drops with input");

        // R5 force makes a line pending
        acc(2'd2, 2'd2, 32'h0008_0002, "R5 set force line 35");
        acc(2'd2, 2'd1, 32'h0000_0002, "R5 line 35 pending by force");
        acc(2'd3, 2'd2, 32'h0008_0002, "R5 clear force line 35");
        acc(2'd2, 2'd1, 32'h0000_0002, "R5 line 35 no longer pending");

        // R6 / R7 priority windows and hardwired low bits
        acc(2'd1, 2'd3, 32'hFFFF_0008, "R6 write priority window 8");
        acc(2'd2, 2'd3, 32'h0000_0008, "R7 priority reads 0xCCCC");
        acc(2'd1, 2'd3, 32'h7123_0008, "R6 per-field write");
        acc(2'd3, 2'd3, 32'h0040_0008, "R6 clear field bit");
        acc(2'd2, 2'd3, 32'h0000_0008, "R7 readback after clear");
        acc(2'd2, 2'd3, 32'h0000_0000, "R6 priority window 0 untouched");

        // R8 request against preemption level; line 35 priority is 4
        acc(2'd2, 2'd0, 32'h0008_0002, "R8 enable line 35");
        set_pre(4'd0, 1'b0, "R8 enabled but not pending");
        acc(2'd2, 2'd2, 32'h0008_0002, "R8 force line 35");
        set_pre(4'd4, 1'b1, "R8 priority equal to level");
        set_pre(4'd5, 1'b0, "R8 priority below level");
        acc(2'd2, 2'd1, 32'h0000_0002, "R8 masked line still pending");
        set_pre(4'd0, 1'b1, "R8 level zero");
        acc(2'd3, 2'd0, 32'h0008_0002, "R8 disable line 35");
        set_pre(4'd0, 1'b0, "R8 disabled line silent");

        // R9 lines beyond the count
        acc(2'd1, 2'd0, 32'hFFFF_0002, "R9 write partial window 2");
        acc(2'd2, 2'd0, 32'h0000_0002, "R9 upper bits of window 2 zero");
        acc(2'd1, 2'd2, 32'hFFFF_0003, "R9 write absent window 3");
        acc(2'd2, 2'd2, 32'h0000_0003, "R9 absent window 3 reads zero");
        acc(2'd1, 2'd3, 32'hFFFF_000A, "R9 write absent priority window 10");
        acc(2'd2, 2'd3, 32'h0000_000A, "R9 absent priority window reads zero");
        acc(2'd2, 2'd2, 32'h0000_0000, "R9 force window 0 unchanged");

        repeat (2) @(posedge clk);
        done = 1'b1;
        chk_on = 1'b0;
        summary();
        $finish;
    end
endmodule